// File: doc/BRIEF.md
# Token-Metered Freeze Controller for a Latency-Insensitive Node

This block wraps a small stateful model (a running accumulator) as a latency-insensitive node. The node reads its operand from an input FIFO and writes its result to an output FIFO. One model cycle completes only when every input FIFO holds a token and every output FIFO has room. The same clock-independent firing rule covers a second pair of 1-bit ports. The node consumes one token per model cycle from a token-in FIFO and emits one token bit per model cycle into a token-out FIFO. The node ignores the value of the incoming token. Only its presence matters.

A debug controller meters the token-in FIFO. To halt the node at model cycle n, it issues n-1 tokens in total since reset and drains every token the node emits. The node then stalls waiting for token n, with all state as of the start of model cycle n. While the node is frozen, a debugger can read the accumulator or overwrite it. Further tokens resume the node one model cycle each, which allows single-stepping. A model cycle can take any number of clocks, because it waits for operand data or for output room. The halt point is counted in model cycles only. Each node carries its own controller, so one node can be frozen without stopping any other.

Top module: `tok_freeze_node`

## Requirements
- R1: After reset, `model_cycle` is 0, `frozen` is 1, `m_valid` is 0 and `s_ready` is 1.
- R2: A model cycle fires only when the operand FIFO is non-empty, the token-in FIFO is non-empty and both the result and token-out FIFOs have room. With tokens granted but no operand data, `model_cycle` stays at 0 and `frozen` is 0.
- R3: Command RUN (`cmd_op`=2'b00) with argument n (n ≥ 1) sets the total token grant to n-1. The node then fires exactly n-1 cycles since reset and halts with `model_cycle` = n-1 and `frozen` = 1. `model_cycle` increments by exactly one per firing and never exceeds the grant.
- R4: Each firing adds the operand to the accumulator and emits the new sum, modulo 2^DW, on `m_data`, in operand order.
- R5: Command READ (`cmd_op`=2'b10) while frozen returns the accumulator on `rsp_data`, with `rsp_err`=0. Every command gets a one-cycle `rsp_valid` pulse in the cycle after it is accepted.
- R6: Command WRITE (`cmd_op`=2'b11) while frozen loads `cmd_arg[DW-1:0]` into the accumulator. Later results build on the written value.
- R7: READ or WRITE while not frozen sets `rsp_err`=1. Such a WRITE leaves the accumulator unchanged.
- R8: Command STEP (`cmd_op`=2'b01) grants exactly one more token. From a frozen state, `model_cycle` rises by exactly one and the node freezes again.
- R9: RUN with n=0, or with n-1 below the number of tokens already issued, sets `rsp_err`=1 and changes nothing.
- R10: The token bit of each model cycle is bit 0 of that cycle's new sum. `tok_bit` shows the last token drained from the token-out FIFO.
- R11: Both data FIFOs are 2 deep. While `m_ready` is low, `m_valid` and `m_data` hold, and the node fires exactly 2 more cycles (filling the result FIFO) and then stalls without losing data. The input FIFO then fills and drops `s_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Operand valid |
| s_ready | output | 1 | Operand FIFO has room |
| s_data | input | DW | Operand word |
| m_valid | output | 1 | Result available |
| m_ready | input | 1 | Result consumer ready |
| m_data | output | DW | Result word (new sum) |
| cmd_valid | input | 1 | Debug command strobe |
| cmd_op | input | 2 | 00 RUN, 01 STEP, 10 READ, 11 WRITE |
| cmd_arg | input | CW | Target cycle n (RUN) or write value (WRITE) |
| rsp_valid | output | 1 | Response pulse, one cycle after a command |
| rsp_err | output | 1 | Command rejected |
| rsp_data | output | DW | Accumulator value for READ |
| model_cycle | output | CW | Number of completed model cycles |
| frozen | output | 1 | Node halted on an empty token-in FIFO with the grant used up |
| tok_bit | output | 1 | Last token bit drained from the token-out FIFO |

## Verification
The assertions check the following on every clock:
- the cycle counter steps by exactly one per firing and never passes the grant;
- a write never coincides with a firing;
- every command gets a one-cycle response;
- state access while running is always rejected;
- a stalled result holds under back-pressure.

Some behaviours only the bench scenarios can show. These are:
- halting at the exact requested model cycle while operand data arrives late;
- the frozen value matching a running-sum reference at several halt points;
- a rejected write leaving the state untouched;
- single steps resuming from a written value;
- the exact number of firings that back-pressure allows before the node stalls.

// File: rtl/tfn_pkg.sv
package tfn_pkg;
    typedef enum logic [1:0] {
        OP_RUN   = 2'b00,
        OP_STEP  = 2'b01,
        OP_READ  = 2'b10,
        OP_WRITE = 2'b11
    } dbg_op_e;
endpackage

// File: rtl/tfn_fifo.sv
module tfn_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0]   rd;
        logic [AW-1:0]   wr;
        logic [CNTW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        ptr_d   = ptr_q;
        full    = (ptr_q.cnt == CNTW'(DEPTH));
        empty   = (ptr_q.cnt == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = mem_q[ptr_q.rd];
        if (do_push) begin
            ptr_d.wr = (ptr_q.wr == AW'(DEPTH - 1)) ? '0 : ptr_q.wr + AW'(1);
        end
        if (do_pop) begin
            ptr_d.rd = (ptr_q.rd == AW'(DEPTH - 1)) ? '0 : ptr_q.rd + AW'(1);
        end
        if (do_push && !do_pop) begin
            ptr_d.cnt = ptr_q.cnt + CNTW'(1);
        end else if (do_pop && !do_push) begin
            ptr_d.cnt = ptr_q.cnt - CNTW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[ptr_q.wr] <= din;
        end
    end
endmodule

// File: rtl/tfn_accum_core.sv
module tfn_accum_core #(
    parameter int DW         = 16,
    parameter int CW         = 16,
    parameter bit TOK_PARITY = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [DW-1:0] din,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] acc,
    output logic [DW-1:0] result,
    output logic          tok_bit,
    output logic [CW-1:0] cycles
);
    typedef struct packed {
        logic [CW-1:0] cyc;
        logic [DW-1:0] acc;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        result = st_q.acc + din;
        if (fire) begin
            st_d.acc = result;
            st_d.cyc = st_q.cyc + CW'(1);
        end else if (wr_en) begin
            st_d.acc = wr_data;
        end
    end

    generate
        if (TOK_PARITY) begin : g_tok_parity
            assign tok_bit = ^result;
        end else begin : g_tok_lsb
            assign tok_bit = result[0];
        end
    endgenerate

    assign acc    = st_q.acc;
    assign cycles = st_q.cyc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tfn_dbg_ctrl.sv
module tfn_dbg_ctrl
    import tfn_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [CW-1:0] cmd_arg,
    input  logic [DW-1:0] acc,
    input  logic          tokin_full,
    input  logic          tokin_empty,
    input  logic          tokout_valid,
    input  logic          tokout_bit,
    output logic          tokin_push,
    output logic          tokout_pop,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_data,
    output logic          frozen,
    output logic          tok_bit,
    output logic [CW-1:0] grant
);
    typedef struct packed {
        logic [CW-1:0] target;
        logic [CW-1:0] issued;
        logic          rsp_valid;
        logic          rsp_err;
        logic [DW-1:0] rsp_data;
        logic          last_bit;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    dbg_op_e op;
    logic [CW-1:0] arg_m1;

    assign op = dbg_op_e'(cmd_op);

    always_comb begin
        st_d       = st_q;
        frozen     = tokin_empty && (st_q.issued == st_q.target);
        tokin_push = (st_q.issued != st_q.target) && !tokin_full;
        if (tokin_push) begin
            st_d.issued = st_q.issued + CW'(1);
        end
        tokout_pop = tokout_valid;
        if (tokout_valid) begin
            st_d.last_bit = tokout_bit;
        end
        st_d.rsp_valid = cmd_valid;
        st_d.rsp_err   = 1'b0;
        st_d.rsp_data  = '0;
        wr_en          = 1'b0;
        wr_data        = cmd_arg[DW-1:0];
        arg_m1         = cmd_arg - CW'(1);
        if (cmd_valid) begin
            unique case (op)
                OP_RUN: begin
                    if ((cmd_arg == '0) || (arg_m1 < st_d.issued)) begin
                        st_d.rsp_err = 1'b1;
                    end else begin
                        st_d.target = arg_m1;
                    end
                end
                OP_STEP: begin
                    st_d.target = st_q.target + CW'(1);
                end
                OP_READ: begin
                    if (frozen) begin
                        st_d.rsp_data = acc;
                    end else begin
                        st_d.rsp_err = 1'b1;
                    end
                end
                OP_WRITE: begin
                    if (frozen) begin
                        wr_en = 1'b1;
                    end else begin
                        st_d.rsp_err = 1'b1;
                    end
                end
            endcase
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_err   = st_q.rsp_err;
    assign rsp_data  = st_q.rsp_data;
    assign tok_bit   = st_q.last_bit;
    assign grant     = st_q.target;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tok_freeze_node.sv
module tok_freeze_node #(
    parameter int DW         = 16,
    parameter int CW         = 16,
    parameter int DATA_DEPTH = 2,
    parameter int TOK_DEPTH  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_valid,
    output logic          s_ready,
    input  logic [DW-1:0] s_data,
    output logic          m_valid,
    input  logic          m_ready,
    output logic [DW-1:0] m_data,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [CW-1:0] cmd_arg,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_data,
    output logic [CW-1:0] model_cycle,
    output logic          frozen,
    output logic          tok_bit
);
    logic          in_full, in_empty;
    logic [DW-1:0] in_data;
    logic          out_full, out_empty;
    logic          tokin_push, tokin_full, tokin_empty;
    logic          tok_in_unused;
    logic          tokout_full, tokout_empty, tokout_pop, tokout_data;
    logic          fire, wr_en, core_tok;
    logic [DW-1:0] wr_data, acc, result;
    logic [CW-1:0] ctrl_grant;

    assign fire    = !in_empty && !tokin_empty && !out_full && !tokout_full;
    assign s_ready = !in_full;
    assign m_valid = !out_empty;

    tfn_fifo #(.W(DW), .DEPTH(DATA_DEPTH)) u_in_fifo (
        .clk(clk), .rst_n(rst_n), .push(s_valid), .din(s_data), .pop(fire),
        .dout(in_data), .full(in_full), .empty(in_empty)
    );

    tfn_fifo #(.W(DW), .DEPTH(DATA_DEPTH)) u_out_fifo (
        .clk(clk), .rst_n(rst_n), .push(fire), .din(result), .pop(m_ready),
        .dout(m_data), .full(out_full), .empty(out_empty)
    );

    tfn_fifo #(.W(1), .DEPTH(TOK_DEPTH)) u_tokin_fifo (
        .clk(clk), .rst_n(rst_n), .push(tokin_push), .din(1'b1), .pop(fire),
        .dout(tok_in_unused), .full(tokin_full), .empty(tokin_empty)
    );

    tfn_fifo #(.W(1), .DEPTH(TOK_DEPTH)) u_tokout_fifo (
        .clk(clk), .rst_n(rst_n), .push(fire), .din(core_tok), .pop(tokout_pop),
        .dout(tokout_data), .full(tokout_full), .empty(tokout_empty)
    );

    tfn_accum_core #(.DW(DW), .CW(CW), .TOK_PARITY(1'b0)) u_core (
        .clk(clk), .rst_n(rst_n), .fire(fire), .din(in_data),
        .wr_en(wr_en), .wr_data(wr_data), .acc(acc), .result(result),
        .tok_bit(core_tok), .cycles(model_cycle)
    );

    tfn_dbg_ctrl #(.DW(DW), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .acc(acc), .tokin_full(tokin_full),
        .tokin_empty(tokin_empty), .tokout_valid(!tokout_empty),
        .tokout_bit(tokout_data), .tokin_push(tokin_push),
        .tokout_pop(tokout_pop), .wr_en(wr_en), .wr_data(wr_data),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .frozen(frozen), .tok_bit(tok_bit), .grant(ctrl_grant)
    );
endmodule

// File: rtl/tfn_checker.sv
module tfn_checker #(
    parameter int DW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fire,
    input logic          frozen,
    input logic          wr_en,
    input logic [CW-1:0] model_cycle,
    input logic [CW-1:0] grant,
    input logic          cmd_valid,
    input logic [1:0]    cmd_op,
    input logic          rsp_valid,
    input logic          rsp_err,
    input logic          m_valid,
    input logic          m_ready,
    input logic [DW-1:0] m_data
);
    p_cycle_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> model_cycle == $past(model_cycle) + CW'(1));

    p_cycle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(model_cycle));

    p_within_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        model_cycle <= grant);

    p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);

    p_rsp_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);

    p_write_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !fire);

    p_reject_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op[1] && !frozen) |=> rsp_err);

    p_hold_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
endmodule

bind tok_freeze_node tfn_checker #(.DW(DW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .fire(fire), .frozen(frozen), .wr_en(wr_en),
    .model_cycle(model_cycle), .grant(ctrl_grant), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
);

// File: tb/tok_freeze_node_test.sv
module tok_freeze_node_test;
    localparam int DW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s_valid = 1'b0;
    logic          s_ready;
    logic [DW-1:0] s_data = '0;
    logic          m_valid;
    logic          m_ready = 1'b1;
    logic [DW-1:0] m_data;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [CW-1:0] cmd_arg = '0;
    logic          rsp_valid;
    logic          rsp_err;
    logic [DW-1:0] rsp_data;
    logic [CW-1:0] model_cycle;
    logic          frozen;
    logic          tok_bit;

    int total = 0;
    int bad = 0;
    int out_cnt = 0;
    int nword = 0;
    bit took = 1'b0;
    bit feed_en = 1'b0;
    logic [DW-1:0] ref_acc = '0;
    logic [DW-1:0] in_q[$];
    logic          r_err;
    logic [DW-1:0] r_data;

    always #5 clk = ~clk;

    tok_freeze_node #(.DW(DW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .model_cycle(model_cycle), .frozen(frozen), .tok_bit(tok_bit)
    );

    function automatic logic [DW-1:0] word_of(int k);
        return DW'(k * 37 + 11);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model: running sum over accepted operands, compared at each result handshake (R4).
    always @(negedge clk) begin
        if (rst_n && m_valid && m_ready) begin
            logic [DW-1:0] exp_sum;
            if (in_q.size() == 0) begin
                chk("R4 result without operand", 32'(m_data), 32'hFFFF_FFFF);
            end else begin
                exp_sum = ref_acc + in_q.pop_front();
                ref_acc = exp_sum;
                out_cnt++;
                chk("R4 result word", 32'(m_data), 32'(exp_sum));
            end
        end
        if (rst_n && s_valid && s_ready) begin
            in_q.push_back(s_data);
            took = 1'b1;
        end
    end

    // Operand feeder
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (took) begin
                nword++;
                took = 1'b0;
            end
            s_data  = word_of(nword);
            s_valid = feed_en;
        end
    end

    task automatic do_cmd(input logic [1:0] op, input logic [CW-1:0] arg);
        @(posedge clk);
        #1;
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_arg   = arg;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        r_err  = rsp_err;
        r_data = rsp_data;
        chk("R5 response pulse", 32'(rsp_valid), 32'd1);
    endtask

    task automatic wait_frozen(input string req);
        int lim = 0;
        while (!frozen && lim < 400) begin
            @(posedge clk);
            #1;
            lim++;
        end
        chk(req, 32'(frozen), 32'd1);
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 model_cycle", 32'(model_cycle), 32'd0);
        chk("R1 frozen", 32'(frozen), 32'd1);
        chk("R1 m_valid", 32'(m_valid), 32'd0);
        chk("R1 s_ready", 32'(s_ready), 32'd1);

        // R2: tokens granted, no operand data
        do_cmd(2'b00, CW'(6));
        chk("R3 run accepted", 32'(r_err), 32'd0);
        repeat (10) @(posedge clk);
        #1;
        chk("R2 no fire without data", 32'(model_cycle), 32'd0);
        chk("R2 not frozen", 32'(frozen), 32'd0);

        // R7: state access while running
        do_cmd(2'b10, '0);
        chk("R7 read rejected", 32'(r_err), 32'd1);
        do_cmd(2'b11, CW'(16'h0055));
        chk("R7 write rejected", 32'(r_err), 32'd1);

        // R3: freeze at model cycle 6
        feed_en = 1'b1;
        wait_frozen("R3 frozen at n=6");
        settle();
        chk("R3 cycles at n=6", 32'(model_cycle), 32'd5);
        chk("R4 results count", 32'(out_cnt), 32'd5);
        do_cmd(2'b10, '0);
        chk("R5 read ok", 32'(r_err), 32'd0);
        chk("R5 read value (R7 write ignored)", 32'(r_data), 32'(ref_acc));
        chk("R10 token bit", 32'(tok_bit), 32'(ref_acc[0]));

        // R6: write while frozen
        do_cmd(2'b11, CW'(16'h1000));
        chk("R6 write ok", 32'(r_err), 32'd0);
        ref_acc = 16'h1000;
        do_cmd(2'b10, '0);
        chk("R6 read back", 32'(r_data), 32'h1000);

        // R8: single steps
        for (int i = 0; i < 3; i++) begin
            do_cmd(2'b01, '0);
            wait_frozen("R8 refrozen");
            settle();
            chk("R8 one cycle per step", 32'(model_cycle), 32'(6 + i));
            do_cmd(2'b10, '0);
            chk("R8 R6 state after step", 32'(r_data), 32'(ref_acc));
        end
        chk("R10 token bit after steps", 32'(tok_bit), 32'(ref_acc[0]));

        // R9: invalid RUN targets
        do_cmd(2'b00, CW'(3));
        chk("R9 run below issued", 32'(r_err), 32'd1);
        do_cmd(2'b00, CW'(0));
        chk("R9 run zero", 32'(r_err), 32'd1);
        settle();
        chk("R9 no change", 32'(model_cycle), 32'd8);
        chk("R9 still frozen", 32'(frozen), 32'd1);

        // R11: back-pressure
        m_ready = 1'b0;
        do_cmd(2'b00, CW'(20));
        repeat (30) @(posedge clk);
        #1;
        chk("R11 stall after two", 32'(model_cycle), 32'd10);
        chk("R11 input full", 32'(s_ready), 32'd0);
        chk("R11 result pending", 32'(m_valid), 32'd1);
        m_ready = 1'b1;
        wait_frozen("R11 R3 frozen at n=20");
        settle();
        chk("R3 cycles at n=20", 32'(model_cycle), 32'd19);
        chk("R4 results count at 20", 32'(out_cnt), 32'd19);
        do_cmd(2'b10, '0);
        chk("R5 read at n=20", 32'(r_data), 32'(ref_acc));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule